// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a three-wire serial EEPROM link (chip select, serial clock, data out to the memory, data back from it). A client hands it one request (an operation code, a word address, write data and a burst length) over a valid/ready handshake. The block builds the serial command frame, derives the serial clock from the system clock with a fixed half-period divider, shifts the frame out MSB first and, for reads, collects one or more words back and returns them on a valid/ready read-data stream. After any programming command it releases chip select, waits the minimum deselect time, selects the memory again and polls the returned data line until it reads 1 (ready) or a poll budget runs out. A one-cycle `done` pulse marks the return of the request side to idle; `err` then tells whether the poll timed out.

The memory is addressed in 16-bit words (8 address bits) by default or in bytes (9 address bits) when `WIDE_ORG` is 0. Read data back-pressure: `rd_valid` stays high with `rd_data` unchanged until `rd_ready` is seen high at a clock edge. One finished word can wait in the output register and one more in a holding slot; while the holding slot is occupied the serial clock stops with SK low, so no word is ever dropped. A request is only taken while `req_ready` is high; a request presented at any other time is not a transfer.

Top module: `ser_eeprom_host`

## Requirements
- R1: Each command frame is the bit 1, then a 2-bit opcode (read 10, write 01, erase 11, special 00), then the address MSB first; write and fill-all commands append the data word MSB first. `req_op` codes: 0 read, 1 write, 2 erase, 3 programming-enable, 4 programming-disable, 5 erase-all, 6 fill-all.
- R2: The four special commands use opcode 00 and put a sub-code in the two top address bits (enable 11, disable 00, erase-all 10, fill-all 01), the remaining address bits 0; enable and disable finish without polling.
- R3: SK high and SK low phases each last at least `HALF_CYC` clocks; DI changes only while SK is low, at least `HALF_CYC` clocks before the next SK rise, and is constant while SK is high.
- R4: SK is high only while CS is high; CS rises at least `HALF_CYC` clocks before the first SK rise and falls with SK low; CS stays low at least `CSLOW_CYC` clocks between frames and before status polling.
- R5: A read clocks exactly 3 + address-width + data-width × words SK rises: the single leading dummy bit is skipped and each data bit is sampled once, MSB first.
- R6: A read with `req_len` = n returns n+1 consecutive words in one CS-high window with no dummy bits between them.
- R7: Read words leave on a valid/ready stream; `rd_data` is held while `rd_valid` is high and `rd_ready` low, and SK pauses rather than losing a word.
- R8: After write, erase, erase-all and fill-all the block drops CS, raises it again, and ends with `err` = 0 once the data line reads 1.
- R9: If the data line does not read 1 within `POLL_LIMIT` clocks of the poll window, CS is dropped and the request ends with `err` = 1.
- R10: `req_ready` is high only when idle; it is low from acceptance to `done`; `done` is a one-cycle pulse; a request presented while busy starts nothing.
- R11: After reset CS, SK, DI, `done`, `err` and `rd_valid` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_op | input | 3 | Operation code (R1) |
| req_addr | input | AW | Word or byte address |
| req_wdata | input | DW | Write or fill data |
| req_len | input | LEN_W | Read words minus one |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Consumer takes the read word |
| rd_data | output | DW | Read word |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Poll timeout of the last request |
| ee_cs | output | 1 | Chip select to the memory |
| ee_sk | output | 1 | Serial clock to the memory |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data and ready status from the memory |

## Verification
Every SK phase is `HALF_CYC` clocks long, so a frame of N bits ends N × 2 × `HALF_CYC` clocks after acceptance, a read word is offered one to two clocks after the SK fall that carries its last bit, and `done` comes `CSLOW_CYC` clocks after CS falls. Instead of counting fixed delays, the bench waits on `done` and on read handshakes, sampling at the falling clock edge, and a behavioural memory model counts SK rises per CS window to prove the frame length. A timing monitor measures every SK phase, DI setup and CS low interval in clocks against the parameters.

// File: rtl/seh_pkg.sv
package seh_pkg;
  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_ERASE     = 3'd2,
    OP_PROG_ON   = 3'd3,
    OP_PROG_OFF  = 3'd4,
    OP_CLEAR_ALL = 3'd5,
    OP_FILL_ALL  = 3'd6
  } seh_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SHIFT, S_READ, S_PGAP, S_POLL, S_END
  } seh_state_e;
endpackage

// File: rtl/seh_clkgen.sv
module seh_clkgen #(
  parameter int HALF_CYC = 13,
  localparam int CW = $clog2(HALF_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sk,
  output logic rise,
  output logic fall
);
  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = run && (cnt == CW'(HALF_CYC - 1));
  assign rise = tick && !sk;
  assign fall = tick && sk;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      sk  <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      sk  <= ~sk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/seh_cmdframe.sv
module seh_cmdframe
  import seh_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  localparam int FW = 3 + AW + DW,
  localparam int NBW = $clog2(FW + 1)
) (
  input  logic [2:0]     op,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [FW-1:0]  frame,
  output logic [NBW-1:0] nbits,
  output logic           is_read,
  output logic           needs_poll
);
  logic [1:0]    opc;
  logic [AW-1:0] afield;
  logic          with_data;

  always_comb begin
    opc        = 2'b00;
    afield     = '0;
    with_data  = 1'b0;
    is_read    = 1'b0;
    needs_poll = 1'b0;
    case (seh_op_e'(op))
      OP_READ:      begin opc = 2'b10; afield = addr; is_read = 1'b1; end
      OP_WRITE:     begin opc = 2'b01; afield = addr; with_data = 1'b1; needs_poll = 1'b1; end
      OP_ERASE:     begin opc = 2'b11; afield = addr; needs_poll = 1'b1; end
      OP_PROG_ON:   afield = {2'b11, {(AW-2){1'b0}}};
      OP_CLEAR_ALL: begin afield = {2'b10, {(AW-2){1'b0}}}; needs_poll = 1'b1; end
      OP_FILL_ALL:  begin afield = {2'b01, {(AW-2){1'b0}}}; with_data = 1'b1; needs_poll = 1'b1; end
      default:      afield = '0;  // disable and unused codes
    endcase
    frame              = '0;
    frame[FW-1 -: 3]   = {1'b1, opc};
    frame[FW-4 -: AW]  = afield;
    if (with_data) frame[DW-1:0] = wdata;
    nbits = with_data ? NBW'(FW) : NBW'(3 + AW);
  end
endmodule

// File: rtl/seh_rxword.sv
module seh_rxword #(
  parameter int DW = 16,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic          din,
  output logic          last,
  output logic          pend,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] sr;
  logic [DW-1:0] pword;
  logic [BW-1:0] bitcnt;

  assign last = (bitcnt == BW'(DW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr       <= '0;
      pword    <= '0;
      bitcnt   <= '0;
      pend     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (pend && (!rd_valid || rd_ready)) begin
        rd_valid <= 1'b1;
        rd_data  <= pword;
        pend     <= 1'b0;
      end else if (rd_ready) begin
        rd_valid <= 1'b0;
      end
      if (sample) begin
        sr     <= {sr[DW-2:0], din};
        bitcnt <= last ? '0 : bitcnt + 1'b1;
        if (last) begin
          pword <= {sr[DW-2:0], din};
          pend  <= 1'b1;
        end
      end
    end
  end

  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample && last |-> !pend);
endmodule

// File: rtl/ser_eeprom_host.sv
module ser_eeprom_host
  import seh_pkg::*;
#(
  parameter bit WIDE_ORG   = 1'b1,
  parameter int HALF_CYC   = 13,
  parameter int CSLOW_CYC  = 13,
  parameter int POLL_LIMIT = 500000,
  parameter int MAX_WORDS  = 8,
  localparam int DW    = WIDE_ORG ? 16 : 8,
  localparam int AW    = WIDE_ORG ? 8 : 9,
  localparam int LEN_W = $clog2(MAX_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LEN_W-1:0] req_len,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [DW-1:0]    rd_data,
  output logic             done,
  output logic             err,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_di,
  input  logic             ee_do
);
  localparam int FW  = 3 + AW + DW;
  localparam int NBW = $clog2(FW + 1);
  localparam int TW  = $clog2(POLL_LIMIT + CSLOW_CYC + 1);

  seh_state_e       state;
  logic [FW-1:0]    shreg;
  logic [NBW-1:0]   bitleft;
  logic [LEN_W-1:0] wleft;
  logic [TW-1:0]    tmr;
  logic             rd_op, poll_op;
  logic             do_m, do_s;
  logic [FW-1:0]    f_frame;
  logic [NBW-1:0]   f_nbits;
  logic             f_read, f_poll;
  logic             sk_run, sk_rise, sk_fall;
  logic             rx_last, rx_pend;
  logic             req_fire;

  assign req_ready = (state == S_IDLE) && !rx_pend;
  assign req_fire  = req_valid && req_ready;
  assign ee_di     = shreg[FW-1];
  assign sk_run    = ((state == S_SHIFT) || (state == S_READ)) && !rx_pend;

  seh_cmdframe #(.AW(AW), .DW(DW)) u_frame (
    .op(req_op), .addr(req_addr), .wdata(req_wdata),
    .frame(f_frame), .nbits(f_nbits), .is_read(f_read), .needs_poll(f_poll));

  seh_clkgen #(.HALF_CYC(HALF_CYC)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(sk_run),
    .sk(ee_sk), .rise(sk_rise), .fall(sk_fall));

  seh_rxword #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample(sk_fall && (state == S_READ)), .din(do_s),
    .last(rx_last), .pend(rx_pend),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data));

  // two-stage capture of the asynchronous return line
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      do_m <= 1'b0;
      do_s <= 1'b0;
    end else begin
      do_m <= ee_do;
      do_s <= do_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      shreg   <= '0;
      bitleft <= '0;
      wleft   <= '0;
      tmr     <= '0;
      rd_op   <= 1'b0;
      poll_op <= 1'b0;
      ee_cs   <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_fire) begin
          shreg   <= f_frame;
          bitleft <= f_nbits;
          wleft   <= req_len;
          rd_op   <= f_read;
          poll_op <= f_poll;
          ee_cs   <= 1'b1;
          err     <= 1'b0;
          state   <= S_SHIFT;
        end
        S_SHIFT: if (sk_fall) begin
          shreg   <= shreg << 1;
          bitleft <= bitleft - 1'b1;
          if (bitleft == NBW'(1)) begin
            if (rd_op) state <= S_READ;
            else begin
              ee_cs <= 1'b0;
              tmr   <= '0;
              state <= poll_op ? S_PGAP : S_END;
            end
          end
        end
        S_READ: if (sk_fall && rx_last) begin
          if (wleft == '0) begin
            ee_cs <= 1'b0;
            tmr   <= '0;
            state <= S_END;
          end else begin
            wleft <= wleft - 1'b1;
          end
        end
        S_PGAP: if (tmr == TW'(CSLOW_CYC - 1)) begin
          ee_cs <= 1'b1;
          tmr   <= '0;
          state <= S_POLL;
        end else tmr <= tmr + 1'b1;
        S_POLL: if (tmr >= TW'(HALF_CYC) && do_s) begin
          ee_cs <= 1'b0;
          tmr   <= '0;
          state <= S_END;
        end else if (tmr == TW'(POLL_LIMIT - 1)) begin
          ee_cs <= 1'b0;
          tmr   <= '0;
          err   <= 1'b1;
          state <= S_END;
        end else tmr <= tmr + 1'b1;
        S_END: if (tmr == TW'(CSLOW_CYC - 1)) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end else tmr <= tmr + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_sk_needs_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);
  assert_cs_falls_sk_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_cs) |-> !ee_sk);
  assert_di_still_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> $stable(ee_di));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ee_cs && !ee_sk);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_err_from_poll_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(ee_cs) && !ee_cs);
endmodule

// File: tb/test_ser_eeprom_host.sv
module test_ser_eeprom_host;
  localparam int HALF = 13;
  localparam int CSL  = 13;
  localparam int PLIM = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [7:0]  req_addr = 8'd0;
  logic [15:0] req_wdata = 16'd0;
  logic [2:0]  req_len = 3'd0;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [15:0] rd_data;
  logic        done, err, ee_cs, ee_sk, ee_di, ee_do;

  always #10 clk = ~clk;

  ser_eeprom_host #(.HALF_CYC(HALF), .CSLOW_CYC(CSL), .POLL_LIMIT(PLIM)) i_ser_eeprom_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .err(err), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [15:0] m_mem [256];
  logic [15:0] exp_mem [256];
  bit   m_en = 0, exp_en = 0, stuck = 0;
  int   busy_until = 0;
  int   m_state = 0, m_cnt = 0, m_rise = 0, last_rises = 0, m_rbit = 0;
  logic [9:0]  m_hdr;
  logic [7:0]  m_addr;
  logic [15:0] m_wd;
  logic [1:0]  m_opc;
  bit   m_reading = 0;
  logic m_do = 1'b0;

  assign ee_do = m_reading ? m_do : ((cyc >= busy_until) && !stuck);

  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      if (m_rise > 0) last_rises = m_rise;
      m_rise = 0; m_state = 0; m_reading = 0; m_cnt = 0;
    end else begin
      m_rise++;
      case (m_state)
        0: if (ee_di) begin m_state = 1; m_cnt = 0; end
        1: begin
          m_hdr = {m_hdr[8:0], ee_di};
          m_cnt++;
          if (m_cnt == 10) begin
            m_opc = m_hdr[9:8]; m_addr = m_hdr[7:0]; m_state = 4;
            case (m_opc)
              2'b10: begin m_reading = 1; m_do = 1'b0; m_rbit = 0; m_state = 3; end
              2'b01: begin m_state = 2; m_cnt = 0; end
              2'b11: if (m_en) begin m_mem[m_addr] = 16'hFFFF; busy_until = cyc + 400; end
              default: case (m_addr[7:6])
                2'b11: m_en = 1;
                2'b00: m_en = 0;
                2'b10: if (m_en) begin
                  for (int i = 0; i < 256; i++) m_mem[i] = 16'hFFFF;
                  busy_until = cyc + 400;
                end
                default: begin m_state = 2; m_cnt = 0; end
              endcase
            endcase
          end
        end
        2: begin
          m_wd = {m_wd[14:0], ee_di};
          m_cnt++;
          if (m_cnt == 16) begin
            m_state = 4;
            if (m_en) begin
              if (m_opc == 2'b01) m_mem[m_addr] = m_wd;
              else for (int i = 0; i < 256; i++) m_mem[i] = m_wd;
              busy_until = cyc + 400;
            end
          end
        end
        3: begin
          m_do = m_mem[m_addr][15 - m_rbit];
          m_rbit++;
          if (m_rbit == 16) begin m_rbit = 0; m_addr = m_addr + 8'd1; end
        end
        default: ;
      endcase
    end
  end

  // ---------------- pin timing monitor (R3, R4) ----------------
  int   viol = 0, sk_len = 0, di_len = 0, csl_len = 0, csh_len = 0;
  logic sk_p = 0, di_p = 0, cs_p = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ee_sk != sk_p) begin
        if (sk_len < HALF) viol++;
        if (ee_sk && (di_len < HALF || csh_len < HALF || !ee_cs)) viol++;
        sk_len = 1;
      end else sk_len++;
      if (ee_di != di_p) begin
        if (ee_sk) viol++;
        di_len = 1;
      end else di_len++;
      if (ee_cs != cs_p) begin
        if (ee_cs && csl_len < CSL) viol++;
        csl_len = 0; csh_len = 0;
      end
      if (ee_cs) csh_len++; else csl_len++;
    end else begin
      csl_len = 1000;
    end
    sk_p = ee_sk; di_p = ee_di; cs_p = ee_cs;
  end

  // ---------------- scoreboard ----------------
  logic [15:0] expq [$];
  bit bp = 0;
  initial forever begin
    @(posedge clk); #2;
    rd_ready = bp ? ((cyc % 1000) == 0) : 1'b1;
  end
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (expq.size() == 0) chk(0, "R6 unexpected read word", {16'h0, rd_data}, 32'h0);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(rd_data == e, "R5/R6/R7 read word", {16'h0, rd_data}, {16'h0, e});
      end
    end
  end

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] a, input logic [15:0] wd,
                         input int len, input bit exp_err, input string tag);
    int guard = 0;
    bit saw_ready = 0;
    int exp_r;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = a; req_wdata = wd; req_len = len[2:0]; req_valid = 1'b1;
    if (op == 3'd0) for (int i = 0; i <= len; i++) expq.push_back(exp_mem[8'(a + i)]);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    while (!done && guard < 40000) begin
      if (req_ready) saw_ready = 1;
      guard++;
      @(negedge clk);
    end
    chk(!saw_ready, {tag, " R10 req_ready low while busy"}, saw_ready, 0);
    chk(done, {tag, " R10 done pulse"}, done, 1);
    chk(err == exp_err, {tag, " R8/R9 err flag"}, err, exp_err);
    exp_r = (op == 3'd0) ? 11 + 16 * (len + 1) : ((op == 3'd1 || op == 3'd6) ? 27 : 11);
    chk(last_rises == exp_r, {tag, " R1/R2/R5 SK rises in frame"}, last_rises, exp_r);
    case (op)
      3'd1: if (exp_en) exp_mem[a] = wd;
      3'd2: if (exp_en) exp_mem[a] = 16'hFFFF;
      3'd3: exp_en = 1;
      3'd4: exp_en = 0;
      3'd5: if (exp_en) for (int i = 0; i < 256; i++) exp_mem[i] = 16'hFFFF;
      3'd6: if (exp_en) for (int i = 0; i < 256; i++) exp_mem[i] = wd;
      default: ;
    endcase
  endtask

  task automatic drain;
    int g = 0;
    while (expq.size() != 0 && g < 20000) begin @(negedge clk); g++; end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    for (int i = 0; i < 256; i++) begin
      m_mem[i] = 16'((i * 16'h0F1D) ^ 16'hC35A);
      exp_mem[i] = 16'((i * 16'h0F1D) ^ 16'hC35A);
    end
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!ee_cs && !ee_sk && !ee_di, "R11 serial pins idle", {ee_cs, ee_sk, ee_di}, 0);
    chk(req_ready && !rd_valid && !done && !err, "R11 handshake reset",
        {req_ready, rd_valid, done, err}, 4'b1000);

    run_cmd(3'd1, 8'd5, 16'h1234, 0, 0, "write while disabled R8");
    run_cmd(3'd0, 8'd5, 16'h0, 0, 0, "read unchanged R5");
    run_cmd(3'd3, 8'd0, 16'h0, 0, 0, "enable R2");
    run_cmd(3'd1, 8'd5, 16'h1234, 0, 0, "write R1");
    run_cmd(3'd1, 8'd6, 16'h8001, 0, 0, "write R8");
    run_cmd(3'd1, 8'd7, 16'h7FFE, 0, 0, "write R8");
    run_cmd(3'd0, 8'd5, 16'h0, 2, 0, "burst R6");
    run_cmd(3'd2, 8'd6, 16'h0, 0, 0, "erase R1");
    run_cmd(3'd0, 8'd5, 16'h0, 1, 0, "burst after erase R6");
    drain();
    bp = 1;
    run_cmd(3'd0, 8'd4, 16'h0, 3, 0, "stalled burst R7");
    drain();
    bp = 0;
    chk(expq.size() == 0, "R7 stalled words all delivered", expq.size(), 0);

    // R10: a request offered while busy is not taken
    @(negedge clk);
    req_op = 3'd0; req_addr = 8'd5; req_len = 3'd0; req_valid = 1'b1;
    expq.push_back(exp_mem[5]);
    @(posedge clk); #1 req_valid = 1'b0;
    repeat (50) @(negedge clk);
    req_op = 3'd1; req_addr = 8'd8; req_wdata = 16'hBEEF; req_valid = 1'b1;
    repeat (200) @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    begin
      bit cs_seen = 0;
      repeat (60) begin @(negedge clk); if (ee_cs) cs_seen = 1; end
      chk(!cs_seen, "R10 busy-time request started nothing", cs_seen, 0);
    end
    run_cmd(3'd0, 8'd8, 16'h0, 0, 0, "R10 location untouched");

    run_cmd(3'd6, 8'd0, 16'h5A3C, 0, 0, "fill all R2");
    run_cmd(3'd0, 8'd200, 16'h0, 1, 0, "read fill R2");
    run_cmd(3'd5, 8'd0, 16'h0, 0, 0, "erase all R2");
    run_cmd(3'd0, 8'd0, 16'h0, 0, 0, "read erased R2");
    run_cmd(3'd4, 8'd0, 16'h0, 0, 0, "disable R2");
    run_cmd(3'd1, 8'd9, 16'h0000, 0, 0, "write after disable R2");
    run_cmd(3'd0, 8'd9, 16'h0, 0, 0, "read after disable R2");
    run_cmd(3'd3, 8'd0, 16'h0, 0, 0, "enable again R2");
    stuck = 1;
    run_cmd(3'd1, 8'd3, 16'h1111, 0, 1, "poll timeout R9");
    stuck = 0;
    chk(!ee_cs, "R9 CS released after timeout", ee_cs, 0);
    run_cmd(3'd0, 8'd3, 16'h0, 0, 0, "recovery read R9");
    run_cmd(3'd1, 8'd3, 16'h2222, 0, 0, "err cleared R8");
    drain();
    chk(expq.size() == 0, "R6 all read words seen", expq.size(), 0);
    chk(viol == 0, "R3/R4 pin timing violations", viol, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule